// File: doc/BRIEF.md
# Busy-Retry Phase Controller

This block drives one outstanding packet on the producer side of a split-transaction serial bus whose consumers can refuse a packet with a busy acknowledge. A request starts the first transmission. Every busy acknowledge carries a phase code, and that code is used on the next transmission. A busied packet is sent again exactly once per fairness interval, and the interval is marked by a pulse from outside. A complete acknowledge ends the transaction with a done pulse.

Retrying is bounded by wall-clock time rather than by a retry count. A timer counts pulses of a fixed-period tick input, starting from the first busy acknowledge. When the timer reaches its limit, the block raises a timeout error and gives up. The limit is a programmable busy limit. When that value is zero, the split-transaction limit is used instead.

In non-supportive mode the block ignores the phase protocol and always transmits with the no-try phase.

Top module: `busyretry_ctrl`

## Requirements
- R1: After reset, `send_o`, `done_o` and `timeout_o` are low and the controller is idle.
- R2: The phase field is 2 bits: 00 no-try, 01 do-try, 10 retry-A, 11 retry-B. If `supportive_i` was low when the request was taken, every transmission of that packet uses 00, whatever phase the acknowledges carry.
- R3: If `supportive_i` is high when a request is taken, the first transmission uses 01 when `first_dotry_i` is high and 00 otherwise. `send_o` is high for one cycle, in the cycle after the one in which `req_i` is sampled in idle.
- R4: In supportive mode, each retransmission uses the phase of the most recent busy acknowledge. A busy acknowledge carrying 00 is taken as 01.
- R5: After a busy acknowledge, no retransmission is made until a fairness interval pulse has arrived after the previous transmission. If such a pulse is already pending, the retransmission appears two cycles after the acknowledge cycle. Otherwise it appears in the cycle after the first pulse that arrives while the block waits.
- R6: At most one retransmission is made per fairness interval. An interval pulse in the same cycle as a transmission is used up by that transmission.
- R7: A complete acknowledge (`ack_valid_i` high, `ack_busy_i` low) gives a one-cycle `done_o` pulse in the next cycle and returns the block to idle.
- R8: The busy timer starts at zero on the first busy acknowledge of a packet. Later busy acknowledges do not restart it. It advances once per cycle in which `tick_i` is high. In the cycle after the count reaches the limit, `timeout_o` pulses for one cycle and the block returns to idle without further transmissions.
- R9: The limit is `busy_limit_i` when that value is nonzero, and `split_limit_i` otherwise. It is captured at the first busy acknowledge.
- R10: If a complete acknowledge arrives in the same cycle as timer expiry, `done_o` pulses and `timeout_o` stays low.
- R11: `req_i` is ignored while a packet is in progress. Acknowledges are ignored while no transmission is awaiting one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a packet (taken only when idle) |
| supportive_i | input | 1 | Use the phase protocol for this packet |
| first_dotry_i | input | 1 | In supportive mode, send the first transmission with do-try |
| ack_valid_i | input | 1 | Acknowledge present |
| ack_busy_i | input | 1 | 1 = busy, 0 = complete |
| ack_phase_i | input | 2 | Phase returned in a busy acknowledge |
| interval_i | input | 1 | Fairness interval pulse |
| tick_i | input | 1 | Fixed-period time base pulse |
| busy_limit_i | input | CNT_W | Busy timeout in ticks (0 = not programmed) |
| split_limit_i | input | CNT_W | Fallback timeout in ticks |
| send_o | output | 1 | Transmit strobe |
| send_phase_o | output | 2 | Phase for the transmission |
| done_o | output | 1 | Transaction completed |
| timeout_o | output | 1 | Busy timeout error |

## Verification
Timer expiry and a complete acknowledge can fall in the same cycle. The bench provokes this by busying a packet with a two-tick limit, sending the retry, and then delivering two ticks so that the count sits at the limit. The complete acknowledge is then presented in exactly that cycle, and the bench expects a done pulse with no timeout. Separately, the bench places an interval pulse in the same cycle as a first transmission. It then checks that this pulse does not permit a retry before the next interval.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [1:0] {
        PH_NOTRY   = 2'b00,
        PH_DOTRY   = 2'b01,
        PH_RETRY_A = 2'b10,
        PH_RETRY_B = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_ACK = 2'd1,
        ST_HOLD     = 2'd2
    } ctl_st_e;

    typedef struct packed {
        ctl_st_e st;
        logic    sup;
        phase_e  ph;
        logic    send;
        logic    done;
        logic    tout;
    } ctl_t;

endpackage

// File: rtl/brc_phase_sel.sv
module brc_phase_sel
    import brc_pkg::*;
(
    input  logic       sup_now_i,
    input  logic       first_dotry_i,
    input  logic       sup_held_i,
    input  logic [1:0] ack_phase_i,
    output phase_e     first_ph_o,
    output phase_e     retry_ph_o
);

    always_comb begin
        if (sup_now_i && first_dotry_i) begin
            first_ph_o = PH_DOTRY;
        end else begin
            first_ph_o = PH_NOTRY;
        end

        if (!sup_held_i) begin
            retry_ph_o = PH_NOTRY;
        end else if (ack_phase_i == 2'b00) begin
            // no-try is not a consumer status; treat it as do-try
            retry_ph_o = PH_DOTRY;
        end else begin
            retry_ph_o = phase_e'(ack_phase_i);
        end
    end

endmodule

// File: rtl/brc_slot_tracker.sv
module brc_slot_tracker (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic interval_i,
    input  logic consume_i,
    output logic avail_o
);

    logic slot_d, slot_q;

    always_comb begin
        avail_o = slot_q | interval_i;
        if (consume_i) begin
            slot_d = 1'b0;
        end else if (interval_i) begin
            slot_d = 1'b1;
        end else begin
            slot_d = slot_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slot_q <= 1'b0;
        end else begin
            slot_q <= slot_d;
        end
    end

    // R6: a transmission always empties the slot
    assert_slot_used_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        consume_i |=> !slot_q);

endmodule

// File: rtl/brc_busy_timer.sv
module brc_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] busy_limit_i,
    input  logic [CNT_W-1:0] split_limit_i,
    output logic             active_o,
    output logic             expired_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (stop_i) begin
            d.active = 1'b0;
            d.cnt    = '0;
        end else if (start_i) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.lim    = (busy_limit_i != '0) ? busy_limit_i : split_limit_i;
        end else if (q.active && tick_i && (q.cnt != CNT_MAX)) begin
            d.cnt = q.cnt + 1'b1;
        end
        active_o  = q.active;
        expired_o = q.active && (q.cnt >= q.lim);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R8: timer begins from zero when started
    assert_start_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !stop_i) |=> (active_o && q.cnt == '0));

    // R8: without a tick the count does not move
    assert_count_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.active && !tick_i && !start_i && !stop_i) |=> $stable(q.cnt));

    // R9: captured limit is kept while the timer runs
    assert_limit_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.active && !start_i && !stop_i) |=> $stable(q.lim));

endmodule

// File: rtl/busyretry_ctrl.sv
module busyretry_ctrl
    import brc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             supportive_i,
    input  logic             first_dotry_i,
    input  logic             ack_valid_i,
    input  logic             ack_busy_i,
    input  logic [1:0]       ack_phase_i,
    input  logic             interval_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] busy_limit_i,
    input  logic [CNT_W-1:0] split_limit_i,
    output logic             send_o,
    output logic [1:0]       send_phase_o,
    output logic             done_o,
    output logic             timeout_o
);

    localparam ctl_t CTL_RST = '{st: ST_IDLE, sup: 1'b0, ph: PH_NOTRY,
                                 send: 1'b0, done: 1'b0, tout: 1'b0};

    ctl_t   d, q;
    phase_e first_ph, retry_ph;
    logic   slot_avail, issue, retry_issue;
    logic   tmr_start, tmr_stop, tmr_active, expired;

    brc_phase_sel u_phase (
        .sup_now_i    (supportive_i),
        .first_dotry_i(first_dotry_i),
        .sup_held_i   (q.sup),
        .ack_phase_i  (ack_phase_i),
        .first_ph_o   (first_ph),
        .retry_ph_o   (retry_ph)
    );

    brc_slot_tracker u_slot (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .interval_i(interval_i),
        .consume_i (issue),
        .avail_o   (slot_avail)
    );

    brc_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (tmr_start),
        .stop_i       (tmr_stop),
        .tick_i       (tick_i),
        .busy_limit_i (busy_limit_i),
        .split_limit_i(split_limit_i),
        .active_o     (tmr_active),
        .expired_o    (expired)
    );

    always_comb begin
        d           = q;
        d.send      = 1'b0;
        d.done      = 1'b0;
        d.tout      = 1'b0;
        issue       = 1'b0;
        retry_issue = 1'b0;
        tmr_start   = 1'b0;
        tmr_stop    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    d.sup  = supportive_i;
                    d.ph   = first_ph;
                    d.send = 1'b1;
                    d.st   = ST_WAIT_ACK;
                    issue  = 1'b1;
                end
            end
            ST_WAIT_ACK: begin
                if (ack_valid_i && !ack_busy_i) begin
                    d.done   = 1'b1;
                    d.st     = ST_IDLE;
                    tmr_stop = 1'b1;
                end else if (expired) begin
                    d.tout   = 1'b1;
                    d.st     = ST_IDLE;
                    tmr_stop = 1'b1;
                end else if (ack_valid_i) begin
                    d.ph      = retry_ph;
                    d.st      = ST_HOLD;
                    tmr_start = !tmr_active;
                end
            end
            ST_HOLD: begin
                if (expired) begin
                    d.tout   = 1'b1;
                    d.st     = ST_IDLE;
                    tmr_stop = 1'b1;
                end else if (slot_avail) begin
                    d.send      = 1'b1;
                    d.st        = ST_WAIT_ACK;
                    issue       = 1'b1;
                    retry_issue = 1'b1;
                end
            end
            default: begin
                d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= CTL_RST;
        end else begin
            q <= d;
        end
    end

    assign send_o       = q.send;
    assign send_phase_o = q.ph;
    assign done_o       = q.done;
    assign timeout_o    = q.tout;

    // Independent record of transmissions within the current interval
    logic sent_win_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sent_win_q <= 1'b0;
        end else if (interval_i) begin
            sent_win_q <= issue;
        end else if (issue) begin
            sent_win_q <= 1'b1;
        end
    end

    assert_one_per_interval_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retry_issue && !interval_i) |-> !sent_win_q);

    assert_retry_on_interval_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_HOLD && interval_i && !expired) |=> send_o);

    assert_notry_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (send_o && !q.sup) |-> (send_phase_o == PH_NOTRY));

    assert_retry_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_WAIT_ACK && ack_valid_i && ack_busy_i && !expired && q.sup)
        |=> (send_phase_o != PH_NOTRY));

    assert_single_event_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({send_o, done_o, timeout_o}));

    assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_quiet_after_timeout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |=> (!send_o && !timeout_o));

    assert_done_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_WAIT_ACK && ack_valid_i && !ack_busy_i) |=> (done_o && !timeout_o));

endmodule

// File: tb/busyretry_ctrl_tb_top.sv
`timescale 1ns/1ps
module busyretry_ctrl_tb_top;

    localparam int CNT_W = 16;
    localparam int NVEC  = 6;

    // {supportive, first_dotry, busy phase 1, busy phase 2, exp first, exp retry1, exp retry2}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0},
        {1'b0, 1'b1, 2'd1, 2'd2, 2'd0, 2'd0, 2'd0},
        {1'b1, 1'b0, 2'd2, 2'd3, 2'd0, 2'd2, 2'd3},
        {1'b1, 1'b1, 2'd3, 2'd2, 2'd1, 2'd3, 2'd2},
        {1'b1, 1'b1, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1},
        {1'b1, 1'b0, 2'd1, 2'd0, 2'd0, 2'd1, 2'd1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0, sup = 1'b0, fdot = 1'b0;
    logic             ack_v = 1'b0, ack_b = 1'b0;
    logic [1:0]       ack_ph = 2'd0;
    logic             intv = 1'b0, tick = 1'b0;
    logic [CNT_W-1:0] blim = 16'd1000, slim = 16'd1000;
    logic             send, done, tout;
    logic [1:0]       ph;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    busyretry_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .supportive_i(sup),
        .first_dotry_i(fdot), .ack_valid_i(ack_v), .ack_busy_i(ack_b),
        .ack_phase_i(ack_ph), .interval_i(intv), .tick_i(tick),
        .busy_limit_i(blim), .split_limit_i(slim), .send_o(send),
        .send_phase_o(ph), .done_o(done), .timeout_o(tout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_req(input logic s, input logic f);
        sup = s; fdot = f; req = 1'b1;
        step();
        req = 1'b0;
    endtask

    task automatic do_ack(input logic busy, input logic [1:0] p);
        ack_v = 1'b1; ack_b = busy; ack_ph = p;
        step();
        ack_v = 1'b0; ack_b = 1'b0; ack_ph = 2'd0;
    endtask

    task automatic do_intv();
        intv = 1'b1;
        step();
        intv = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #12;
        // R1: reset state
        chk("R1 send", int'(send), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 timeout", int'(tout), 0);
        rst_n = 1'b1;
        step();
        chk("R1 idle after release", int'(send | done | tout), 0);

        // Table walk: phase selection (R2 R3 R4) and completion (R7)
        for (int i = 0; i < NVEC; i++) begin
            do_req(VEC[i][11], VEC[i][10]);
            chk("R3 first send strobe", int'(send), 1);
            chk("R2 R3 first phase", int'(ph), int'(VEC[i][5:4]));
            step();
            do_ack(1'b1, VEC[i][9:8]);
            do_intv();
            chk("R4 retry1 phase", int'(ph), int'(VEC[i][3:2]));
            do_ack(1'b1, VEC[i][7:6]);
            do_intv();
            chk("R4 retry2 phase", int'(ph), int'(VEC[i][1:0]));
            do_ack(1'b0, 2'd0);
            chk("R7 done pulse", int'(done), 1);
            step();
            chk("R7 done one cycle", int'(done), 0);
        end

        // R5: no retransmission until an interval pulse
        do_req(1'b1, 1'b0);
        step();
        do_ack(1'b1, 2'd2);
        begin
            int seen = 0;
            for (int k = 0; k < 4; k++) begin
                if (send) seen++;
                step();
            end
            chk("R5 no send without interval", seen, 0);
        end
        do_intv();
        chk("R5 send after interval", int'(send), 1);
        do_ack(1'b0, 2'd0);
        step();

        // R5: pending interval gives retransmission two cycles after the ack
        do_req(1'b1, 1'b0);
        do_intv();
        do_ack(1'b1, 2'd3);
        chk("R5 no send in ack+1", int'(send), 0);
        step();
        chk("R5 pending slot send", int'(send), 1);
        chk("R4 pending slot phase", int'(ph), 3);
        do_ack(1'b1, 2'd2);
        step(); step();
        chk("R6 one send per interval", int'(send), 0);
        do_intv();
        chk("R6 next interval send", int'(send), 1);
        do_ack(1'b0, 2'd0);
        step();

        // R6: interval coinciding with the first send is consumed by it
        sup = 1'b1; fdot = 1'b0; req = 1'b1; intv = 1'b1;
        step();
        req = 1'b0; intv = 1'b0;
        chk("R6 coincident first send", int'(send), 1);
        do_ack(1'b1, 2'd2);
        step(); step();
        chk("R6 coincident pulse used", int'(send), 0);

        // R11: request and acknowledge ignored while holding
        do_req(1'b1, 1'b1);
        chk("R11 req ignored", int'(send), 0);
        do_ack(1'b0, 2'd0);
        chk("R11 ack ignored in hold", int'(done), 0);
        do_intv();
        chk("R11 still retries", int'(send), 1);
        chk("R11 phase kept", int'(ph), 2);
        do_ack(1'b0, 2'd0);
        chk("R7 done after hold", int'(done), 1);
        step();

        // R8: timeout with a later busy ack not restarting the timer
        blim = 16'd3;
        do_req(1'b1, 1'b0);
        step();
        do_ack(1'b1, 2'd2);
        do_tick();
        do_tick();
        do_intv();
        chk("R8 retry before limit", int'(send), 1);
        do_ack(1'b1, 2'd3);
        do_tick();
        chk("R8 no early timeout", int'(tout), 0);
        step();
        chk("R8 timeout pulse", int'(tout), 1);
        step();
        chk("R8 timeout one cycle", int'(tout), 0);
        do_intv();
        chk("R8 idle after timeout", int'(send), 0);

        // R9: zero busy limit falls back to split limit
        blim = 16'd0; slim = 16'd2;
        do_req(1'b0, 1'b0);
        step();
        do_ack(1'b1, 2'd1);
        blim = 16'd50;
        do_tick();
        step();
        chk("R9 not yet expired", int'(tout), 0);
        do_tick();
        step();
        chk("R9 split limit used", int'(tout), 1);
        step();

        // R10: complete ack in the expiry cycle wins
        blim = 16'd2;
        do_req(1'b1, 1'b1);
        step();
        do_ack(1'b1, 2'd1);
        do_intv();
        chk("R10 retry sent", int'(send), 1);
        do_tick();
        do_tick();
        do_ack(1'b0, 2'd0);
        chk("R10 done wins", int'(done), 1);
        chk("R10 no timeout", int'(tout), 0);
        step();
        chk("R10 no late timeout", int'(tout), 0);

        finish_run();
    end

endmodule